// File: doc/BRIEF.md
# Control Register Shadow Write Filter

This block sits beside a processor's control-register write path while a guest runs under a hypervisor. Each guest attempt to change control register 0 or 4, to load the 16-bit machine-status word, or to clear the task-switched flag is presented to it as one operation. A host-ownership mask marks the bits the hypervisor controls, and a read shadow holds the values the guest believes those bits have. The block decides whether the operation must trap to the host, builds the 64-bit exit qualification that describes the access, and computes the value that may actually be written into the register so that host-owned bits are never altered by the guest.

The filter is combinational logic followed by a single output register stage. An operation presented with `op_valid` produces its result with `res_valid` on the next clock. The register file, the decoding of instructions into operations and the computing of addresses are outside the block.

Top module: `cr_shadow_filter`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `op_valid` high, and `exit_req`, `exit_qual`, `commit_val` and `keep_ts` then show the result of that operation.
- R2: For op code 0 (full write of register 0) and op code 1 (full write of register 4), `exit_req` is 1 exactly when (mask AND shadow) differs from (mask AND new value).
- R3: For op codes 0 and 1, `commit_val` is (current AND mask) OR (new value AND NOT mask), whether or not an exit is requested.
- R4: For op code 2 (status-word load) the operand is `new_val[15:0]`; `commit_val[63:4]` equals the current value and `commit_val[3:0]` is (current[3:0] AND m) OR (operand[3:0] AND NOT m), with m = mask[3:0]; mask bits above bit 3 have no effect.
- R5: For op code 2, `exit_req` is 1 when operand bit 0 and mask bit 0 are set while shadow bit 0 is clear, or when bits 3:1 of (mask AND shadow) differ from bits 3:1 of (mask AND operand).
- R6: For op code 3 (task-switched clear), `exit_req` is 1 exactly when mask bit 3 and shadow bit 3 are both set; `commit_val` is the current value with bit 3 cleared, except that bit 3 is kept when `keep_ts` is 1.
- R7: `keep_ts` is 1 only for op code 3 with mask bit 3 set and shadow bit 3 clear; it is 0 for every other operation.
- R8: On an exit from op code 0 or 1, the qualification holds the register number (0 or 4) in bits 3:0, access type 0 in bits 5:4, `src_reg` in bits 11:8, and zero elsewhere.
- R9: On an exit from op code 2, bits 5:4 hold 3, bit 6 holds `mem_operand` and bits 31:16 hold the operand, all other bits zero; on an exit from op code 3, bits 5:4 hold 2 and all other bits are zero.
- R10: When `exit_req` is 0 the qualification is all zeros.
- R11: Op codes 4 to 7 request no exit, give a zero qualification, clear `keep_ts` and commit the current value unchanged.
- R12: While `rst` is high at a clock edge, every output is cleared to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation code (0 write reg 0, 1 write reg 4, 2 status load, 3 TS clear) |
| new_val | input | 64 | Value the guest wants to write; low 16 bits are the status-load operand |
| cur_val | input | 64 | Present content of the target register |
| own_mask | input | 64 | Host-ownership mask for the target register |
| shadow | input | 64 | Read shadow for the target register |
| src_reg | input | 4 | Index of the general register supplying the value |
| mem_operand | input | 1 | Status-load operand came from memory |
| res_valid | output | 1 | Result of the previous cycle's operation is valid |
| exit_req | output | 1 | Operation must trap to the host |
| exit_qual | output | 64 | Exit qualification |
| commit_val | output | 64 | Value that may be written into the register |
| keep_ts | output | 1 | Task-switched flag must stay set |

## Verification
Full writes are tried with new values that agree and disagree with the shadow in owned bits, including the top bit of the word, which separates an exit decided on owned bits from one decided on guest bits and confirms the merge keeps owned bits from the current value. Status loads are tried with bit 0 newly set, with bits 3:1 matching and differing, and with only high bits owned, which tells apart the bit-0 rule, the bits 3:1 rule and the four-bit limit of the mask. The task-switched clear is tried with every combination of mask and shadow bit 3 that changes the outcome, separating the exit case, the keep case and the plain clear. Unused op codes, reset during activity and the single-cycle latency are checked last.

// File: rtl/cr_filt_pkg.sv
package cr_filt_pkg;

  // operation codes presented on op_kind
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_WR_CR0   = 3'd0;
  localparam logic [OPC_W-1:0] OPC_WR_CR4   = 3'd1;
  localparam logic [OPC_W-1:0] OPC_LOAD_MSW = 3'd2;
  localparam logic [OPC_W-1:0] OPC_CLR_TS   = 3'd3;

  // access type field of the qualification
  localparam int ACC_W = 2;
  localparam logic [ACC_W-1:0] ACC_WRITE    = 2'd0;
  localparam logic [ACC_W-1:0] ACC_READ     = 2'd1;
  localparam logic [ACC_W-1:0] ACC_CLR_TS   = 2'd2;
  localparam logic [ACC_W-1:0] ACC_LOAD_MSW = 2'd3;

  // register number field
  localparam int CRN_W = 4;
  localparam logic [CRN_W-1:0] CRN_0 = 4'd0;
  localparam logic [CRN_W-1:0] CRN_4 = 4'd4;

  // qualification field positions (decoded by the host)
  localparam int QF_CRN_LSB  = 0;
  localparam int QF_ACC_LSB  = 4;
  localparam int QF_MEM_BIT  = 6;
  localparam int QF_SRC_LSB  = 8;
  localparam int QF_OPND_LSB = 16;

endpackage

// File: rtl/cr_fullwr_decide.sv
module cr_fullwr_decide #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] new_val,
  input  logic [DATA_W-1:0] cur_val,
  input  logic [DATA_W-1:0] own_mask,
  input  logic [DATA_W-1:0] shadow,
  output logic              exit_hit,
  output logic [DATA_W-1:0] merged
);

  logic [DATA_W-1:0] owned_shadow;
  logic [DATA_W-1:0] owned_new;

  always_comb begin
    owned_shadow = own_mask & shadow;
    owned_new    = own_mask & new_val;
    exit_hit     = (owned_shadow != owned_new);
    merged       = (cur_val & own_mask) | (new_val & ~own_mask);
  end

endmodule

// File: rtl/cr_msw_decide.sv
module cr_msw_decide #(
  parameter int DATA_W = 64,
  parameter int LOW_W  = 4
) (
  input  logic [DATA_W-1:0] cur_val,
  input  logic [LOW_W-1:0]  mask_lo,
  input  logic [LOW_W-1:0]  shadow_lo,
  input  logic [LOW_W-1:0]  opnd_lo,
  output logic              exit_hit,
  output logic [DATA_W-1:0] merged
);

  logic             set_bit0;
  logic             upper_diff;
  logic [LOW_W-1:0] low_res;

  always_comb begin
    set_bit0   = mask_lo[0] & opnd_lo[0] & ~shadow_lo[0];
    upper_diff = ((mask_lo[LOW_W-1:1] & shadow_lo[LOW_W-1:1]) !=
                  (mask_lo[LOW_W-1:1] & opnd_lo[LOW_W-1:1]));
    exit_hit   = set_bit0 | upper_diff;
    low_res    = (cur_val[LOW_W-1:0] & mask_lo) | (opnd_lo & ~mask_lo);
    merged     = {cur_val[DATA_W-1:LOW_W], low_res};
  end

endmodule

// File: rtl/cr_ts_decide.sv
module cr_ts_decide #(
  parameter int DATA_W = 64,
  parameter int TS_BIT = 3
) (
  input  logic [DATA_W-1:0] cur_val,
  input  logic              mask_ts,
  input  logic              shadow_ts,
  output logic              exit_hit,
  output logic              keep,
  output logic [DATA_W-1:0] merged
);

  localparam logic [DATA_W-1:0] ONE_HOT = {{(DATA_W-1){1'b0}}, 1'b1} << TS_BIT;

  always_comb begin
    exit_hit = mask_ts & shadow_ts;
    keep     = mask_ts & ~shadow_ts;
    merged   = keep ? cur_val : (cur_val & ~ONE_HOT);
  end

endmodule

// File: rtl/cr_qual_build.sv
module cr_qual_build
  import cr_filt_pkg::*;
#(
  parameter int QUAL_W = 64,
  parameter int IDX_W  = 4,
  parameter int MSW_W  = 16
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [CRN_W-1:0]  crn,
  input  logic [IDX_W-1:0]  src_reg,
  input  logic              mem_operand,
  input  logic [MSW_W-1:0]  opnd,
  output logic [QUAL_W-1:0] qual
);

  always_comb begin
    qual = '0;
    qual[QF_CRN_LSB +: CRN_W] = crn;
    qual[QF_ACC_LSB +: ACC_W] = acc;
    if (acc == ACC_WRITE) begin
      qual[QF_SRC_LSB +: IDX_W] = src_reg;
    end
    if (acc == ACC_LOAD_MSW) begin
      qual[QF_MEM_BIT]             = mem_operand;
      qual[QF_OPND_LSB +: MSW_W]   = opnd;
    end
  end

endmodule

// File: rtl/cr_shadow_filter.sv
module cr_shadow_filter
  import cr_filt_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int QUAL_W    = 64,
  parameter int IDX_W     = 4,
  parameter int MSW_W     = 16,
  parameter int MSW_LOW_W = 4,
  parameter int TS_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [DATA_W-1:0] new_val,
  input  logic [DATA_W-1:0] cur_val,
  input  logic [DATA_W-1:0] own_mask,
  input  logic [DATA_W-1:0] shadow,
  input  logic [IDX_W-1:0]  src_reg,
  input  logic              mem_operand,
  output logic              res_valid,
  output logic              exit_req,
  output logic [QUAL_W-1:0] exit_qual,
  output logic [DATA_W-1:0] commit_val,
  output logic              keep_ts
);

  logic              fw_exit;
  logic [DATA_W-1:0] fw_val;
  logic              msw_exit;
  logic [DATA_W-1:0] msw_val;
  logic              ts_exit;
  logic              ts_keep;
  logic [DATA_W-1:0] ts_val;

  logic              nxt_exit;
  logic              nxt_keep;
  logic [DATA_W-1:0] nxt_val;
  logic [ACC_W-1:0]  nxt_acc;
  logic [CRN_W-1:0]  nxt_crn;
  logic [QUAL_W-1:0] raw_qual;
  logic [QUAL_W-1:0] nxt_qual;

  cr_fullwr_decide #(.DATA_W(DATA_W)) u_fullwr (
    .new_val  (new_val),
    .cur_val  (cur_val),
    .own_mask (own_mask),
    .shadow   (shadow),
    .exit_hit (fw_exit),
    .merged   (fw_val)
  );

  cr_msw_decide #(.DATA_W(DATA_W), .LOW_W(MSW_LOW_W)) u_msw (
    .cur_val   (cur_val),
    .mask_lo   (own_mask[MSW_LOW_W-1:0]),
    .shadow_lo (shadow[MSW_LOW_W-1:0]),
    .opnd_lo   (new_val[MSW_LOW_W-1:0]),
    .exit_hit  (msw_exit),
    .merged    (msw_val)
  );

  cr_ts_decide #(.DATA_W(DATA_W), .TS_BIT(TS_BIT)) u_ts (
    .cur_val   (cur_val),
    .mask_ts   (own_mask[TS_BIT]),
    .shadow_ts (shadow[TS_BIT]),
    .exit_hit  (ts_exit),
    .keep      (ts_keep),
    .merged    (ts_val)
  );

  always_comb begin
    nxt_exit = 1'b0;
    nxt_keep = 1'b0;
    nxt_val  = cur_val;
    nxt_acc  = ACC_WRITE;
    nxt_crn  = CRN_0;
    case (op_kind)
      OPC_WR_CR0: begin
        nxt_exit = fw_exit;
        nxt_val  = fw_val;
      end
      OPC_WR_CR4: begin
        nxt_exit = fw_exit;
        nxt_val  = fw_val;
        nxt_crn  = CRN_4;
      end
      OPC_LOAD_MSW: begin
        nxt_exit = msw_exit;
        nxt_val  = msw_val;
        nxt_acc  = ACC_LOAD_MSW;
      end
      OPC_CLR_TS: begin
        nxt_exit = ts_exit;
        nxt_keep = ts_keep;
        nxt_val  = ts_val;
        nxt_acc  = ACC_CLR_TS;
      end
      default: begin
        nxt_exit = 1'b0;
      end
    endcase
  end

  cr_qual_build #(.QUAL_W(QUAL_W), .IDX_W(IDX_W), .MSW_W(MSW_W)) u_qual (
    .acc         (nxt_acc),
    .crn         (nxt_crn),
    .src_reg     (src_reg),
    .mem_operand (mem_operand),
    .opnd        (new_val[MSW_W-1:0]),
    .qual        (raw_qual)
  );

  assign nxt_qual = nxt_exit ? raw_qual : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      exit_req   <= 1'b0;
      exit_qual  <= '0;
      commit_val <= '0;
      keep_ts    <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        exit_req   <= nxt_exit;
        exit_qual  <= nxt_qual;
        commit_val <= nxt_val;
        keep_ts    <= nxt_keep;
      end
    end
  end

endmodule

// File: rtl/cr_shadow_filter_chk.sv
module cr_shadow_filter_chk #(
  parameter int DATA_W = 64,
  parameter int QUAL_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_kind,
  input logic [DATA_W-1:0] cur_val,
  input logic [DATA_W-1:0] own_mask,
  input logic              res_valid,
  input logic              exit_req,
  input logic [QUAL_W-1:0] exit_qual,
  input logic [DATA_W-1:0] commit_val,
  input logic              keep_ts
);

  AST_RES_FOLLOWS_OP: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);  // R1

  AST_RES_IDLE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);  // R1

  AST_OWNED_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind <= 3'd1) |=>
      (((commit_val ^ $past(cur_val)) & $past(own_mask)) == '0));  // R3

  AST_MSW_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd2) |=>
      (commit_val[DATA_W-1:4] == $past(cur_val[DATA_W-1:4])));  // R4

  AST_KEEP_NO_EXIT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && keep_ts) |-> !exit_req);  // R7

  AST_QUAL_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (exit_qual[QUAL_W-1:32] == '0));  // R9

  AST_QUIET_QUAL: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !exit_req) |-> (exit_qual == '0));  // R10

  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind[2]) |=>
      (!exit_req && !keep_ts && commit_val == $past(cur_val)));  // R11

endmodule

bind cr_shadow_filter cr_shadow_filter_chk #(.DATA_W(DATA_W), .QUAL_W(QUAL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_kind    (op_kind),
  .cur_val    (cur_val),
  .own_mask   (own_mask),
  .res_valid  (res_valid),
  .exit_req   (exit_req),
  .exit_qual  (exit_qual),
  .commit_val (commit_val),
  .keep_ts    (keep_ts)
);

// File: tb/cr_shadow_filter_bench.sv
module cr_shadow_filter_bench;

  localparam int CLK_P = 10;
  localparam int DW    = 64;
  localparam int NVEC  = 14;

  typedef struct packed {
    logic [2:0]    op;
    logic [DW-1:0] nv;
    logic [DW-1:0] cur;
    logic [DW-1:0] msk;
    logic [DW-1:0] shd;
    logic [3:0]    src;
    logic          mem;
    logic          x_exit;
    logic [DW-1:0] x_qual;
    logic [DW-1:0] x_commit;
    logic          x_keep;
  } vec_t;

  // op, new, cur, mask, shadow, src, mem, exit, qual, commit, keep
  localparam vec_t VECS [NVEC] = '{
    // R2 R3: write reg 0, owned bits agree -> no exit
    '{3'd0, 64'h01, 64'h11, 64'h21, 64'h01, 4'h5, 1'b0, 1'b0, 64'h0,   64'h01, 1'b0},
    // R2 R3 R8: write reg 0, owned bit 5 differs
    '{3'd0, 64'h20, 64'h11, 64'h21, 64'h01, 4'h5, 1'b0, 1'b1, 64'h500, 64'h01, 1'b0},
    // R2 R3: write reg 4, agree
    '{3'd1, 64'hA5, 64'hF0, 64'h0F, 64'h05, 4'h9, 1'b0, 1'b0, 64'h0,   64'hA0, 1'b0},
    // R2 R3 R8: write reg 4, differ
    '{3'd1, 64'hA6, 64'hF0, 64'h0F, 64'h05, 4'h9, 1'b0, 1'b1, 64'h904, 64'hA0, 1'b0},
    // R2 R3 R8: top bit owned
    '{3'd1, 64'h8000_0000_0000_0001, 64'h0, 64'h8000_0000_0000_0000, 64'h0, 4'hF, 1'b0,
      1'b1, 64'hF04, 64'h1, 1'b0},
    // R5 R9: status load sets owned bit 0, shadow clear, memory operand
    '{3'd2, 64'h0001, 64'hFF00, 64'h1, 64'h0, 4'h3, 1'b1, 1'b1, 64'h1_0070, 64'hFF00, 1'b0},
    // R4 R5: bit 0 owned, shadow set, operand clear -> no exit, bit 0 kept
    '{3'd2, 64'h0000, 64'hFF01, 64'h1, 64'h1, 4'h3, 1'b1, 1'b0, 64'h0, 64'hFF01, 1'b0},
    // R4 R5: bits 3:1 owned and equal
    '{3'd2, 64'h1234_0004, 64'h5555_5555_5555_5553, 64'hE, 64'h4, 4'h7, 1'b1,
      1'b0, 64'h0, 64'h5555_5555_5555_5552, 1'b0},
    // R5 R9: bits 3:1 differ, register operand, src not reported
    '{3'd2, 64'hBEE8, 64'h5555_5555_5555_5553, 64'hE, 64'h4, 4'h7, 1'b0,
      1'b1, 64'hBEE8_0030, 64'h5555_5555_5555_5552, 1'b0},
    // R4: only high bits owned -> no effect on status load
    '{3'd2, 64'h00F5, 64'hA0, 64'hF0, 64'h0, 4'h0, 1'b0, 1'b0, 64'h0, 64'hA5, 1'b0},
    // R6 R9: TS owned and shadow set -> exit
    '{3'd3, 64'h0, 64'h3F, 64'h8, 64'h8, 4'h6, 1'b0, 1'b1, 64'h20, 64'h37, 1'b0},
    // R6 R7: TS owned, shadow clear -> keep
    '{3'd3, 64'h0, 64'h3F, 64'h8, 64'h0, 4'h6, 1'b0, 1'b0, 64'h0, 64'h3F, 1'b1},
    // R6 R7: TS not owned -> plain clear
    '{3'd3, 64'h0, 64'h3F, 64'h0, 64'h8, 4'h6, 1'b0, 1'b0, 64'h0, 64'h37, 1'b0},
    // R11: unused op code
    '{3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'h2, 1'b1,
      1'b0, 64'h0, 64'h1234, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          op_valid;
  logic [2:0]    op_kind;
  logic [DW-1:0] new_val;
  logic [DW-1:0] cur_val;
  logic [DW-1:0] own_mask;
  logic [DW-1:0] shadow;
  logic [3:0]    src_reg;
  logic          mem_operand;
  logic          res_valid;
  logic          exit_req;
  logic [63:0]   exit_qual;
  logic [DW-1:0] commit_val;
  logic          keep_ts;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cr_shadow_filter u_cr_shadow_filter (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .new_val    (new_val),
    .cur_val    (cur_val),
    .own_mask   (own_mask),
    .shadow     (shadow),
    .src_reg    (src_reg),
    .mem_operand(mem_operand),
    .res_valid  (res_valid),
    .exit_req   (exit_req),
    .exit_qual  (exit_qual),
    .commit_val (commit_val),
    .keep_ts    (keep_ts)
  );

  task automatic check64(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2/R3/R8/R10";
      3'd2:       return "R4/R5/R9/R10";
      3'd3:       return "R6/R7/R9";
      default:    return "R11";
    endcase
  endfunction

  task automatic present(input vec_t v);
    @(negedge clk);
    op_valid    = 1'b1;
    op_kind     = v.op;
    new_val     = v.nv;
    cur_val     = v.cur;
    own_mask    = v.msk;
    shadow      = v.shd;
    src_reg     = v.src;
    mem_operand = v.mem;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_kind = '0; new_val = '0; cur_val = '0;
    own_mask = '0; shadow = '0; src_reg = '0; mem_operand = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check64("R12", "res_valid", 64'(res_valid), 64'h0);
    check64("R12", "exit_req",  64'(exit_req),  64'h0);
    check64("R12", "exit_qual", exit_qual, 64'h0);
    check64("R12", "commit_val", commit_val, 64'h0);
    check64("R12", "keep_ts",   64'(keep_ts),   64'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      present(VECS[i]);
      check64("R1", "res_valid", 64'(res_valid), 64'h1);
      check64(tag_of(VECS[i].op), "exit_req", 64'(exit_req), 64'(VECS[i].x_exit));
      check64(tag_of(VECS[i].op), "exit_qual", exit_qual, VECS[i].x_qual);
      check64(tag_of(VECS[i].op), "commit_val", commit_val, VECS[i].x_commit);
      check64(tag_of(VECS[i].op), "keep_ts", 64'(keep_ts), 64'(VECS[i].x_keep));
    end

    // R1: result strobe lasts a single cycle
    @(negedge clk);
    check64("R1", "res_valid idle", 64'(res_valid), 64'h0);

    // R7: keep then a full write clears keep_ts
    present(VECS[11]);
    check64("R7", "keep_ts set", 64'(keep_ts), 64'h1);
    present(VECS[0]);
    check64("R7", "keep_ts after write", 64'(keep_ts), 64'h0);

    // R12: reset while an exit result is held and another op is presented
    present(VECS[1]);
    check64("R12", "pre-reset exit", 64'(exit_req), 64'h1);
    @(negedge clk);
    rst = 1'b1;
    op_valid = 1'b1;
    @(negedge clk);
    check64("R12", "res_valid in reset", 64'(res_valid), 64'h0);
    check64("R12", "exit_req in reset", 64'(exit_req), 64'h0);
    check64("R12", "exit_qual in reset", exit_qual, 64'h0);
    check64("R12", "commit_val in reset", commit_val, 64'h0);
    rst = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule